// File: doc/BRIEF.md
# Serial Byte Register Access Port

This block is the slave side of a synchronous serial link with one half-duplex data line, a serial clock and an active-low select. The host opens every transaction with an 8-bit instruction that selects read or write, a byte count of one to three, and a 4-bit start location. The block then moves that many bytes between the line and a small byte-wide register bank, which sits outside this block and is reached through a simple address, write-strobe and read-data port.

The data line is split into an input, an output and an output enable so that a pad can be placed around it. All serial inputs pass through double-flop synchronisers into the system clock domain. The direction in which the location moves between bytes and the bit order used inside each data byte are supplied as level inputs, normally taken from a command register kept in the bank. If the serial clock stops for a programmable number of system cycles, the interface drops back to waiting for an instruction and leaves the bank contents untouched.

Top module: `sreg_serial_if`

## Requirements
- R1: After reset `sd_oe` is 0 and `reg_we` is 0, and the block waits for an instruction byte.
- R2: The instruction is always shifted in MSB first, whatever `lsb_first` says. Bit 7 selects the direction (0 write, 1 read). Bits 6:5 give the byte count (00 one, 01 two, 10 three, 11 is also taken as three). Bit 4 is ignored. Bits 3:0 give the start location.
- R3: On a write, each data bit is sampled on a falling serial clock edge. After the eighth bit `reg_we` pulses for exactly one cycle, with the byte on `reg_wdata` and its location on `reg_addr`.
- R4: With `addr_down` at 0 the location rises by one after each byte and wraps from 15 to 0.
- R5: With `addr_down` at 1 the location falls by one after each byte and wraps from 0 to 15.
- R6: With `lsb_first` at 1 data bytes go LSB first in both directions. With `lsb_first` at 0 they go MSB first.
- R7: On a read, `sd_oe` rises after the instruction's last falling edge. The first data bit is valid before the first rising edge, and each later bit appears only after a rising edge.
- R8: `sd_oe` returns to 0 after the falling edge of the last read bit. A write never drives the line.
- R9: While `cs_n` is high, serial clock edges are ignored, and a partly received instruction is discarded.
- R10: Raising `cs_n` in the middle of a read does not release `sd_oe`, and the read resumes where it stopped once `cs_n` falls again.
- R11: If no serial clock edge occurs for `TIMEOUT_CYC` system cycles, the transfer is dropped, `sd_oe` goes to 0, the next byte is taken as an instruction, and the bank is not written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sck | input | 1 | Serial clock from the host, asynchronous |
| cs_n | input | 1 | Active-low select, may be tied low |
| sd_in | input | 1 | Data line as seen at the pad |
| sd_out | output | 1 | Data driven toward the pad during reads |
| sd_oe | output | 1 | Output enable for the data pad |
| addr_down | input | 1 | 1 makes the location fall between bytes |
| lsb_first | input | 1 | 1 makes data bytes travel LSB first |
| reg_addr | output | 4 | Bank location being accessed |
| reg_wdata | output | 8 | Byte to store in the bank |
| reg_we | output | 1 | One-cycle write strobe |
| reg_rdata | input | 8 | Bank content at `reg_addr`, combinational |

## Verification
A bit counter that slips by one shows up at the next byte boundary as a write to the wrong location, or as a byte rotated by one position, so a reference model of the bank exposes it within eight serial clocks. A wrong location step shows up on the second byte of a multi-byte transfer. A stuck transfer state shows up as the line still being driven after a read, or as the next instruction being taken as data. The timeout and select cases are placed where a misaligned frame would corrupt the following write at once.

// File: rtl/sif_pkg.sv
package sif_pkg;
  localparam int BYTE_W = 8;
  localparam int LOC_W  = 4;
  localparam int BIT_W  = $clog2(BYTE_W);

  typedef enum logic [1:0] {ST_INSTR, ST_WR, ST_RD} sif_state_t;

  function automatic logic pick_bit(input logic [BYTE_W-1:0] b,
                                    input logic [BIT_W-1:0] idx,
                                    input logic lsbf);
    logic [BIT_W-1:0] rev;
    rev = BIT_W'(BYTE_W - 1) - idx;
    return lsbf ? b[idx] : b[rev];
  endfunction
endpackage

// File: rtl/sif_sync.sv
module sif_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stg[0] <= RST_VAL;
    else     stg[0] <= d;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stg[i] <= RST_VAL;
      else     stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/sif_timeout.sv
module sif_timeout #(
  parameter int LIMIT = 250000
) (
  input  logic clk,
  input  logic rst,
  input  logic activity,
  output logic fire
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIM   = CW'(LIMIT);
  localparam logic [CW-1:0] LIM_M = CW'(LIMIT - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || activity) cnt <= '0;
    else if (cnt != LIM) cnt <= cnt + 1'b1;
  end

  assign fire = (cnt == LIM_M) && !activity;

  assert_cnt_bound_R11: assert property (@(posedge clk) disable iff (rst)
    cnt <= LIM);
endmodule

// File: rtl/sif_engine.sv
module sif_engine
  import sif_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              sck_rise,
  input  logic              sck_fall,
  input  logic              cs_n_s,
  input  logic              sd_s,
  input  logic              abort,
  input  logic              addr_down,
  input  logic              lsb_first,
  input  logic [BYTE_W-1:0] rdata,
  output logic [LOC_W-1:0]  loc,
  output logic [BYTE_W-1:0] wdata,
  output logic              we,
  output logic              sd_out,
  output logic              sd_oe
);
  sif_state_t        st;
  logic [BIT_W-1:0]  bitcnt;
  logic [BYTE_W-1:0] sh_in;
  logic [BYTE_W-1:0] rbyte;
  logic [1:0]        left;
  logic              load_pend;

  logic              fall_ok, rise_ok, last_bit;
  logic [BYTE_W-1:0] msb_byte, data_byte;
  logic [LOC_W-1:0]  loc_next;

  assign fall_ok   = sck_fall && !cs_n_s;
  assign rise_ok   = sck_rise && !cs_n_s;
  assign last_bit  = (bitcnt == BIT_W'(BYTE_W - 1));
  assign msb_byte  = {sh_in[BYTE_W-2:0], sd_s};
  assign data_byte = lsb_first ? {sd_s, sh_in[BYTE_W-1:1]} : msb_byte;
  assign loc_next  = addr_down ? loc - 1'b1 : loc + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_INSTR;
      bitcnt    <= '0;
      sh_in     <= '0;
      rbyte     <= '0;
      left      <= '0;
      load_pend <= 1'b0;
      loc       <= '0;
      wdata     <= '0;
      we        <= 1'b0;
      sd_out    <= 1'b0;
      sd_oe     <= 1'b0;
    end else begin
      we <= 1'b0;
      if (abort) begin
        st        <= ST_INSTR;
        bitcnt    <= '0;
        load_pend <= 1'b0;
        sd_oe     <= 1'b0;
      end else begin
        if (we) loc <= loc_next;
        if (load_pend) begin
          load_pend <= 1'b0;
          rbyte     <= rdata;
          sd_out    <= pick_bit(rdata, '0, lsb_first);
          sd_oe     <= 1'b1;
        end
        case (st)
          ST_INSTR: begin
            if (cs_n_s) begin
              bitcnt <= '0;
            end else if (sck_fall) begin
              sh_in <= msb_byte;
              if (last_bit) begin
                bitcnt <= '0;
                loc    <= msb_byte[LOC_W-1:0];
                left   <= (msb_byte[6:5] == 2'b11) ? 2'd2 : msb_byte[6:5];
                if (msb_byte[7]) begin
                  st        <= ST_RD;
                  load_pend <= 1'b1;
                end else begin
                  st <= ST_WR;
                end
              end else begin
                bitcnt <= bitcnt + 1'b1;
              end
            end
          end
          ST_WR: begin
            if (fall_ok) begin
              sh_in <= data_byte;
              if (last_bit) begin
                bitcnt <= '0;
                we     <= 1'b1;
                wdata  <= data_byte;
                if (left == 2'd0) st <= ST_INSTR;
                else              left <= left - 1'b1;
              end else begin
                bitcnt <= bitcnt + 1'b1;
              end
            end
          end
          ST_RD: begin
            if (rise_ok && bitcnt != '0)
              sd_out <= pick_bit(rbyte, bitcnt, lsb_first);
            if (fall_ok) begin
              if (last_bit) begin
                bitcnt <= '0;
                if (left == 2'd0) begin
                  st    <= ST_INSTR;
                  sd_oe <= 1'b0;
                end else begin
                  left      <= left - 1'b1;
                  loc       <= loc_next;
                  load_pend <= 1'b1;
                end
              end else begin
                bitcnt <= bitcnt + 1'b1;
              end
            end
          end
          default: st <= ST_INSTR;
        endcase
      end
    end
  end

  // R3: the strobe lasts one cycle
  assert_we_pulse_R3: assert property (@(posedge clk) disable iff (rst)
    we |=> !we);

  // R4 and R5: location moves one step after each written byte
  assert_loc_step_R4: assert property (@(posedge clk) disable iff (rst)
    (we && !abort) |=> (loc == ($past(addr_down) ? $past(loc) - 4'd1
                                                 : $past(loc) + 4'd1)));

  // R8: the line is driven only inside a read
  assert_oe_in_read_R8: assert property (@(posedge clk) disable iff (rst)
    sd_oe |-> (st == ST_RD));

  // R9: a deselected instruction phase keeps no partial bits
  assert_cs_discard_R9: assert property (@(posedge clk) disable iff (rst)
    (st == ST_INSTR && cs_n_s) |=> (bitcnt == '0));
endmodule

// File: rtl/sreg_serial_if.sv
module sreg_serial_if
  import sif_pkg::*;
#(
  parameter int TIMEOUT_CYC = 250000,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       sck,
  input  logic       cs_n,
  input  logic       sd_in,
  output logic       sd_out,
  output logic       sd_oe,
  input  logic       addr_down,
  input  logic       lsb_first,
  output logic [3:0] reg_addr,
  output logic [7:0] reg_wdata,
  output logic       reg_we,
  input  logic [7:0] reg_rdata
);
  logic [2:0] raw_in, syn_in;
  logic       sck_s, cs_s, sd_s, sck_q;
  logic       rise, fall, tmo_fire;

  assign raw_in = {cs_n, sck, sd_in};

  sif_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk (clk), .rst (rst), .d (raw_in), .q (syn_in)
  );

  assign cs_s  = syn_in[2];
  assign sck_s = syn_in[1];
  assign sd_s  = syn_in[0];

  always_ff @(posedge clk) begin
    if (rst) sck_q <= 1'b0;
    else     sck_q <= sck_s;
  end

  assign rise = sck_s && !sck_q;
  assign fall = !sck_s && sck_q;

  sif_timeout #(.LIMIT(TIMEOUT_CYC)) u_tmo (
    .clk (clk), .rst (rst), .activity (rise || fall), .fire (tmo_fire)
  );

  sif_engine u_eng (
    .clk       (clk),
    .rst       (rst),
    .sck_rise  (rise),
    .sck_fall  (fall),
    .cs_n_s    (cs_s),
    .sd_s      (sd_s),
    .abort     (tmo_fire),
    .addr_down (addr_down),
    .lsb_first (lsb_first),
    .rdata     (reg_rdata),
    .loc       (reg_addr),
    .wdata     (reg_wdata),
    .we        (reg_we),
    .sd_out    (sd_out),
    .sd_oe     (sd_oe)
  );

  // R11: a timeout releases the line on the next cycle
  assert_tmo_release_R11: assert property (@(posedge clk) disable iff (rst)
    tmo_fire |=> !sd_oe);
endmodule

// File: tb/sreg_serial_if_bench.sv
`timescale 1ns/1ps
module sreg_serial_if_bench;
  localparam int TMO  = 300;
  localparam int HALF = 8;

  logic clk = 1'b0;
  logic rst, sck, cs_n, sd_in, addr_down, lsb_first;
  logic sd_out, sd_oe, reg_we;
  logic [3:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;

  logic [7:0] bank [16];
  logic [7:0] model [16];
  int exp_a[$];
  int exp_d[$];
  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  sreg_serial_if #(.TIMEOUT_CYC(TMO)) u_sreg_serial_if (
    .clk (clk), .rst (rst), .sck (sck), .cs_n (cs_n), .sd_in (sd_in),
    .sd_out (sd_out), .sd_oe (sd_oe), .addr_down (addr_down),
    .lsb_first (lsb_first), .reg_addr (reg_addr), .reg_wdata (reg_wdata),
    .reg_we (reg_we), .reg_rdata (reg_rdata)
  );

  assign reg_rdata = bank[reg_addr];

  always @(posedge clk) if (reg_we) bank[reg_addr] <= reg_wdata;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // R3: every strobe matches the next expected bank write
  always @(negedge clk) begin
    if (!rst && reg_we) begin
      if (exp_a.size() == 0) begin
        chk(1'b0, "R3", "unexpected write at", int'(reg_addr), -1);
      end else begin
        chk(reg_addr == exp_a[0], "R3", "write location", int'(reg_addr), exp_a[0]);
        chk(reg_wdata == exp_d[0], "R3", "write data", int'(reg_wdata), exp_d[0]);
        void'(exp_a.pop_front());
        void'(exp_d.pop_front());
      end
    end
  end

  task automatic summary();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    sd_in = b;
    tick(HALF);
    sck = 1'b1;
    tick(HALF);
    sck = 1'b0;
    tick(2);
  endtask

  task automatic send_byte(input logic [7:0] b, input logic lsbf);
    for (int k = 0; k < 8; k++) send_bit(lsbf ? b[k] : b[7-k]);
  endtask

  function automatic int count_of(input logic [1:0] code);
    return (code == 2'b00) ? 1 : (code == 2'b01) ? 2 : 3;
  endfunction

  task automatic wr(input logic [3:0] a, input logic [1:0] code, input logic b4,
                    input logic [7:0] d0, input logic [7:0] d1, input logic [7:0] d2,
                    input logic dn, input logic lsbf);
    logic [7:0] d [3];
    logic [3:0] cur;
    d = '{d0, d1, d2};
    addr_down = dn;
    lsb_first = lsbf;
    cur = a;
    send_byte({1'b0, code, b4, a}, 1'b0);
    for (int i = 0; i < count_of(code); i++) begin
      exp_a.push_back(int'(cur));
      exp_d.push_back(int'(d[i]));
      model[cur] = d[i];
      send_byte(d[i], lsbf);
      cur = dn ? cur - 4'd1 : cur + 4'd1;
    end
    tick(6);
    chk(exp_a.size() == 0, "R3", "pending writes", exp_a.size(), 0);
    chk(sd_oe == 1'b0, "R8", "oe after write", int'(sd_oe), 0);
  endtask

  task automatic rd_bits(input logic [7:0] e, input int from, input int upto,
                         input logic lsbf, input string req);
    for (int k = from; k < upto; k++) begin
      tick(HALF);
      sck = 1'b1;
      tick(HALF);
      chk(sd_oe == 1'b1, "R7", "oe during read", int'(sd_oe), 1);
      chk(sd_out == (lsbf ? e[k] : e[7-k]), req, "read bit",
          int'(sd_out), int'(lsbf ? e[k] : e[7-k]));
      sck = 1'b0;
      tick(2);
    end
  endtask

  task automatic rd(input logic [3:0] a, input logic [1:0] code,
                    input logic dn, input logic lsbf, input string req);
    logic [3:0] cur;
    addr_down = dn;
    lsb_first = lsbf;
    cur = a;
    send_byte({1'b1, code, 1'b0, a}, 1'b0);
    for (int i = 0; i < count_of(code); i++) begin
      rd_bits(model[cur], 0, 8, lsbf, req);
      cur = dn ? cur - 4'd1 : cur + 4'd1;
    end
    tick(8);
    chk(sd_oe == 1'b0, "R8", "oe after last read bit", int'(sd_oe), 0);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) begin
      bank[i]  = 8'h00;
      model[i] = 8'h00;
    end
    rst = 1'b1; sck = 1'b0; cs_n = 1'b0; sd_in = 1'b0;
    addr_down = 1'b0; lsb_first = 1'b0;
    tick(5);
    chk(sd_oe == 1'b0, "R1", "oe in reset", int'(sd_oe), 0);
    chk(reg_we == 1'b0, "R1", "we in reset", int'(reg_we), 0);
    rst = 1'b0;
    tick(5);
    chk(sd_oe == 1'b0, "R1", "oe after reset", int'(sd_oe), 0);

    // R2 R3: single byte, bit 4 set in instruction
    wr(4'd3, 2'b00, 1'b1, 8'hA5, 8'h00, 8'h00, 1'b0, 1'b0);
    // R4: three bytes upward across the wrap
    wr(4'd14, 2'b10, 1'b0, 8'h11, 8'h22, 8'h33, 1'b0, 1'b0);
    // R5: two bytes downward across the wrap
    wr(4'd0, 2'b01, 1'b0, 8'h5C, 8'hC7, 8'h00, 1'b1, 1'b0);
    // R6: LSB-first data, instruction still MSB first
    wr(4'd5, 2'b00, 1'b0, 8'h1E, 8'h00, 8'h00, 1'b0, 1'b1);
    // R2: code 11 moves three bytes
    wr(4'd8, 2'b11, 1'b0, 8'h81, 8'h42, 8'h24, 1'b0, 1'b0);

    // R7 R8 R4: upward read across the wrap
    rd(4'd14, 2'b10, 1'b0, 1'b0, "R7");
    // R5 R6: downward LSB-first read
    rd(4'd5, 2'b01, 1'b1, 1'b1, "R6");
    rd(4'd9, 2'b00, 1'b0, 1'b0, "R2");

    // R9: partial instruction abandoned by deselect, edges ignored while high
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b1);
    cs_n = 1'b1;
    tick(6);
    send_bit(1'b0); send_bit(1'b1); send_bit(1'b0);
    chk(exp_a.size() == 0 && sd_oe == 1'b0, "R9", "activity while deselected",
        int'(sd_oe), 0);
    cs_n = 1'b0;
    tick(6);
    wr(4'd9, 2'b00, 1'b0, 8'h6B, 8'h00, 8'h00, 1'b0, 1'b0);

    // R10: deselect mid-read keeps the line driven
    lsb_first = 1'b0;
    addr_down = 1'b0;
    send_byte({1'b1, 2'b00, 1'b0, 4'd3}, 1'b0);
    rd_bits(model[3], 0, 3, 1'b0, "R10");
    cs_n = 1'b1;
    tick(20);
    chk(sd_oe == 1'b1, "R10", "oe while deselected mid-read", int'(sd_oe), 1);
    cs_n = 1'b0;
    tick(6);
    rd_bits(model[3], 3, 8, 1'b0, "R10");
    tick(8);
    chk(sd_oe == 1'b0, "R8", "oe after resumed read", int'(sd_oe), 0);

    // R11: stalled instruction is dropped
    send_bit(1'b0); send_bit(1'b1); send_bit(1'b1);
    tick(TMO + 40);
    wr(4'd2, 2'b00, 1'b0, 8'h3D, 8'h00, 8'h00, 1'b0, 1'b0);

    // R11: stalled read releases the line, bank unchanged
    send_byte({1'b1, 2'b00, 1'b0, 4'd9}, 1'b0);
    rd_bits(model[9], 0, 2, 1'b0, "R11");
    tick(TMO + 40);
    chk(sd_oe == 1'b0, "R11", "oe after timeout", int'(sd_oe), 0);
    chk(exp_a.size() == 0, "R11", "no write from timeout", exp_a.size(), 0);
    rd(4'd9, 2'b00, 1'b0, 1'b0, "R11");
    rd(4'd2, 2'b00, 1'b0, 1'b0, "R11");

    tick(10);
    summary();
    $finish;
  end
endmodule